// File: doc/BRIEF.md
# Fuse Shadow Word Bank with Sticky Access Locks

The bank keeps a host-visible copy of every fuse word. A fuse sequencer fills a word by presenting a reload: the word index, the fuse data, and two quality flags that say whether the fuse read was disturbed or failed. The host reaches the same words through a simple register port. That port reads and writes shadow words and sets lock bits. It also reads the per-word quality flags and a debug-enable status bit.

Each word has four sticky lock bits: a permanent write lock, a program lock, a shadow-write lock and a shadow-read lock. It also has a disturbed flag and an error flag. Each of these six kinds is held as a bitmap. The bitmap is packed 32 words per 32-bit row, and a word's bit sits in row `index >> 5` at bit `index & 31`. The shadow-write lock blocks host writes to the word. The shadow-read lock makes a reload store zero instead of the fuse value. The permanent and program locks are held and reported for the fuse programmer, which lives outside this block. Every reload reports a status code, and every host read of a shadow word reports one as well.

Top module: `shadow_lock_bank`

## Requirements
- R1: After reset every shadow word, every lock bit and every flag bit reads as zero.
- R2: Shadow word i is at byte address 0x200 + 4*i. A host write stores the data. A host read returns the data with `host_rvalid` high in the cycle after `host_rd`.
- R3: A host write to a shadow word whose shadow-write lock bit is set leaves that word unchanged.
- R4: A reload of an in-range index stores `rl_data` into the word. `rl_done` is high in the following cycle, together with `rl_stat`.
- R5: A reload of a word whose shadow-read lock bit is set stores zero instead of `rl_data`.
- R6: The bitmap rows are at these byte bases, with each row 4 bytes above the one before: disturbed 0x1C, error 0x34, permanent lock 0x4C, program lock 0x64, shadow-write lock 0x7C, shadow-read lock 0x94. Word i maps to row i>>5, bit i&31.
- R7: A host write to a lock row sets every lock bit whose data bit is 1. Writing 0 never clears a lock bit. Lock bits clear only on reset.
- R8: A reload sets the word's disturbed flag and error flag from `rl_disturbed` and `rl_error`, so a clean reload clears both. Host writes to the flag rows have no effect.
- R9: The status code is 2'b01 when the word is disturbed, which takes priority over error. It is 2'b10 when the word has an error only, and 2'b00 when neither flag is set. `rl_stat` reports it for the incoming flags, and `host_rstat` reports it for the stored flags of a shadow word read. Any other read gives 2'b00.
- R10: Byte address 0x14 reads `dbg_en` at bit 10 and zero in all other bits.
- R11: A host read of an unaligned or unmapped address, including shadow index 96 and above, returns zero. A host write to such an address changes nothing.
- R12: When a reload and a host write hit the same word in the same cycle, the reload value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW | Host byte address |
| host_wdata | input | DW | Host write data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| host_rdata | output | DW | Read data |
| host_rstat | output | 2 | Status code of the shadow word read |
| rl_valid | input | 1 | Reload request from the fuse sequencer |
| rl_idx | input | IW | Word index of the reload |
| rl_data | input | DW | Fuse data of the reload |
| rl_disturbed | input | 1 | Fuse read was disturbed |
| rl_error | input | 1 | Fuse read failed |
| rl_done | output | 1 | Reload completed, one cycle after `rl_valid` |
| rl_stat | output | 2 | Status code of the reload |
| dbg_en | input | 1 | Debug-enable status to expose |

## Verification
The bench builds the bank with its default parameters: 96 words, 32-bit data and a 10-bit byte address. With 96 words the third bitmap row is completely full, so the bench can reach bit 31 of row 2 (word 95), and shadow index 96 is the first unmapped slot. The 10-bit address also reaches the top of the space at 0x3FC. Together these let the bench test the last word, the first out-of-range index, and the row/bit split across all three rows.

// File: rtl/shadow_lock_bank.sv
module shadow_lock_bank #(
  parameter int NWORDS      = 96,
  parameter int DW          = 32,
  parameter int AW          = 10,
  parameter int SHADOW_BASE = 'h200,
  parameter int DBG_OFF     = 'h14,
  parameter int DBG_BIT     = 10,
  parameter int DIST_OFF    = 'h1C,
  parameter int ERR_OFF     = 'h34,
  parameter int PERM_OFF    = 'h4C,
  parameter int PROG_OFF    = 'h64,
  parameter int SWL_OFF     = 'h7C,
  parameter int SRL_OFF     = 'h94,
  localparam int ROWS       = (NWORDS + 31) / 32,
  localparam int RW         = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int IW         = RW + 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  output logic [1:0]    host_rstat,
  input  logic          rl_valid,
  input  logic [IW-1:0] rl_idx,
  input  logic [DW-1:0] rl_data,
  input  logic          rl_disturbed,
  input  logic          rl_error,
  output logic          rl_done,
  output logic [1:0]    rl_stat,
  input  logic          dbg_en
);

  localparam int NK     = 6;
  localparam int K_DIST = 0;
  localparam int K_ERR  = 1;
  localparam int K_PERM = 2;
  localparam int K_SWL  = 4;
  localparam int K_SRL  = 5;

  function automatic int base_of(input int k);
    case (k)
      0:       return DIST_OFF;
      1:       return ERR_OFF;
      2:       return PERM_OFF;
      3:       return PROG_OFF;
      4:       return SWL_OFF;
      default: return SRL_OFF;
    endcase
  endfunction

  function automatic logic [1:0] code(input logic d, input logic e);
    return d ? 2'b01 : (e ? 2'b10 : 2'b00);
  endfunction

  logic [NWORDS-1:0][DW-1:0]   shadow_q;
  logic [NK-1:0][ROWS*32-1:0]  bm_q;

  logic                        aligned;
  logic                        sh_hit;
  logic                        dbg_hit;
  logic [IW-1:0]               sh_idx;
  logic [NK-1:0]               bm_hit;
  logic [NK-1:0][RW-1:0]       bm_row;
  logic                        rl_in;
  logic [DW-1:0]               rd_next;
  logic [1:0]                  rd_stat;
  int                          wa;

  assign aligned = (host_addr[1:0] == 2'b00);
  assign rl_in   = int'(rl_idx) < NWORDS;

  always_comb begin
    wa      = int'(host_addr[AW-1:2]);
    sh_hit  = aligned && wa >= SHADOW_BASE / 4 && wa < SHADOW_BASE / 4 + NWORDS;
    sh_idx  = IW'(wa - SHADOW_BASE / 4);
    dbg_hit = aligned && wa == DBG_OFF / 4;
    for (int k = 0; k < NK; k++) begin
      bm_hit[k] = aligned && wa >= base_of(k) / 4 && wa < base_of(k) / 4 + ROWS;
      bm_row[k] = RW'(wa - base_of(k) / 4);
    end
  end

  always_comb begin
    rd_next = '0;
    rd_stat = 2'b00;
    if (sh_hit) begin
      rd_next = shadow_q[sh_idx];
      rd_stat = code(bm_q[K_DIST][sh_idx], bm_q[K_ERR][sh_idx]);
    end
    for (int k = 0; k < NK; k++)
      if (bm_hit[k]) rd_next = DW'(bm_q[k][{bm_row[k], 5'b0} +: 32]);
    if (dbg_hit) rd_next[DBG_BIT] = dbg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q    <= '0;
      bm_q        <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      host_rstat  <= 2'b00;
      rl_done     <= 1'b0;
      rl_stat     <= 2'b00;
    end else begin
      host_rvalid <= host_rd;
      host_rdata  <= host_rd ? rd_next : '0;
      host_rstat  <= host_rd ? rd_stat : 2'b00;
      if (host_wr) begin
        if (sh_hit && !bm_q[K_SWL][sh_idx]) shadow_q[sh_idx] <= host_wdata;
        for (int k = K_PERM; k < NK; k++)
          if (bm_hit[k])
            bm_q[k][{bm_row[k], 5'b0} +: 32] <= bm_q[k][{bm_row[k], 5'b0} +: 32] | 32'(host_wdata);
      end
      rl_done <= rl_valid;
      rl_stat <= rl_valid ? code(rl_disturbed, rl_error) : 2'b00;
      if (rl_valid && rl_in) begin
        shadow_q[rl_idx]     <= bm_q[K_SRL][rl_idx] ? '0 : rl_data;
        bm_q[K_DIST][rl_idx] <= rl_disturbed;
        bm_q[K_ERR][rl_idx]  <= rl_error;
      end
    end
  end

endmodule

// File: rtl/shadow_lock_bank_chk.sv
module shadow_lock_bank_chk #(
  parameter int NWORDS      = 96,
  parameter int DW          = 32,
  parameter int AW          = 10,
  parameter int SHADOW_BASE = 'h200,
  localparam int ROWS       = (NWORDS + 31) / 32,
  localparam int RW         = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int IW         = RW + 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       host_wr,
  input logic                       host_rd,
  input logic [AW-1:0]              host_addr,
  input logic                       host_rvalid,
  input logic [DW-1:0]              host_rdata,
  input logic                       rl_valid,
  input logic [IW-1:0]              rl_idx,
  input logic [DW-1:0]              rl_data,
  input logic                       rl_disturbed,
  input logic                       rl_done,
  input logic [1:0]                 rl_stat,
  input logic                       sh_hit,
  input logic [IW-1:0]              sh_idx,
  input logic [NWORDS-1:0][DW-1:0]  shadow_q,
  input logic [5:0][ROWS*32-1:0]    bm_q
);

  p_rvalid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  p_swlock_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && sh_hit && bm_q[4][sh_idx] && !(rl_valid && rl_idx == sh_idx)
    |=> shadow_q[$past(sh_idx)] == $past(shadow_q[sh_idx]));

  p_reload_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rl_valid |=> rl_done);

  p_rdlock_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rl_valid && int'(rl_idx) < NWORDS && bm_q[5][rl_idx] |=> shadow_q[$past(rl_idx)] == '0);

  p_locks_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_q[5:2] & $past(bm_q[5:2])) == $past(bm_q[5:2]));

  p_dist_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rl_valid && int'(rl_idx) < NWORDS |=> bm_q[0][$past(rl_idx)] == $past(rl_disturbed));

  p_dist_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rl_valid && rl_disturbed |=> rl_stat == 2'b01);

  p_oor_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && int'(host_addr) >= SHADOW_BASE + 4 * NWORDS |=> host_rdata == '0);

  p_reload_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rl_valid && host_wr && sh_hit && rl_idx == sh_idx && !bm_q[5][rl_idx]
    |=> shadow_q[$past(rl_idx)] == $past(rl_data));

endmodule

bind shadow_lock_bank shadow_lock_bank_chk #(
  .NWORDS(NWORDS), .DW(DW), .AW(AW), .SHADOW_BASE(SHADOW_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
  .rl_valid(rl_valid), .rl_idx(rl_idx), .rl_data(rl_data),
  .rl_disturbed(rl_disturbed), .rl_done(rl_done), .rl_stat(rl_stat),
  .sh_hit(sh_hit), .sh_idx(sh_idx), .shadow_q(shadow_q), .bm_q(bm_q)
);

// File: tb/shadow_lock_bank_tb_top.sv
module shadow_lock_bank_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic [1:0]  host_rstat;
  logic        rl_valid = 1'b0;
  logic [6:0]  rl_idx = '0;
  logic [31:0] rl_data = '0;
  logic        rl_disturbed = 1'b0, rl_error = 1'b0;
  logic        rl_done;
  logic [1:0]  rl_stat;
  logic        dbg_en = 1'b0;

  shadow_lock_bank dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .host_rstat(host_rstat), .rl_valid(rl_valid),
    .rl_idx(rl_idx), .rl_data(rl_data), .rl_disturbed(rl_disturbed),
    .rl_error(rl_error), .rl_done(rl_done), .rl_stat(rl_stat), .dbg_en(dbg_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model: 0 dist, 1 err, 2 perm, 3 prog, 4 shadow-write lock, 5 shadow-read lock
  logic [31:0] m_sh [96];
  logic        m_bm [6][96];
  int          offs [6] = '{'h1C, 'h34, 'h4C, 'h64, 'h7C, 'h94};

  task automatic model_clear();
    for (int i = 0; i < 96; i++) begin
      m_sh[i] = '0;
      for (int k = 0; k < 6; k++) m_bm[k][i] = 1'b0;
    end
  endtask

  function automatic logic [1:0] st_of(input int i);
    return m_bm[0][i] ? 2'b01 : (m_bm[1][i] ? 2'b10 : 2'b00);
  endfunction

  function automatic logic [31:0] exp_data(input int a);
    logic [31:0] v;
    v = '0;
    if (a % 4 != 0) return v;
    if (a >= 'h200 && a < 'h200 + 384) return m_sh[(a - 'h200) / 4];
    for (int k = 0; k < 6; k++)
      if (a >= offs[k] && a < offs[k] + 12)
        for (int b = 0; b < 32; b++) v[b] = m_bm[k][((a - offs[k]) / 4) * 32 + b];
    if (a == 'h14) v[10] = dbg_en;
    return v;
  endfunction

  function automatic logic [1:0] exp_stat(input int a);
    if (a % 4 == 0 && a >= 'h200 && a < 'h200 + 384) return st_of((a - 'h200) / 4);
    return 2'b00;
  endfunction

  task automatic model_wr(input int a, input logic [31:0] d);
    if (a % 4 != 0) return;
    if (a >= 'h200 && a < 'h200 + 384) begin
      if (!m_bm[4][(a - 'h200) / 4]) m_sh[(a - 'h200) / 4] = d;
    end
    for (int k = 2; k < 6; k++)
      if (a >= offs[k] && a < offs[k] + 12)
        for (int b = 0; b < 32; b++)
          if (d[b]) m_bm[k][((a - offs[k]) / 4) * 32 + b] = 1'b1;
  endtask

  task automatic model_rl(input int i, input logic [31:0] d, input logic ds, input logic er);
    if (i >= 96) return;
    m_sh[i] = m_bm[5][i] ? 32'h0 : d;
    m_bm[0][i] = ds;
    m_bm[1][i] = er;
  endtask

  typedef struct { logic [31:0] d; logic [1:0] s; string tag; } exp_t;
  exp_t sbq [$];

  always @(negedge clk) begin
    exp_t e;
    if (host_rvalid) begin
      if (sbq.size() == 0) check(1'b0, "R2 unexpected rvalid", {host_rstat, host_rdata}, '0);
      else begin
        e = sbq.pop_front();
        check(host_rdata == e.d && host_rstat == e.s, e.tag, {host_rstat, host_rdata}, {e.s, e.d});
      end
    end
  end

  task automatic rd(input int a, input string tag);
    exp_t e;
    e.d = exp_data(a);
    e.s = exp_stat(a);
    e.tag = tag;
    @(negedge clk);
    sbq.push_back(e);
    host_addr = 10'(a);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_addr = 10'(a);
    host_wdata = d;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rl(input int i, input logic [31:0] d, input logic ds, input logic er,
                    input logic [1:0] exp_st, input string tag);
    @(negedge clk);
    rl_idx = 7'(i);
    rl_data = d;
    rl_disturbed = ds;
    rl_error = er;
    rl_valid = 1'b1;
    @(negedge clk);
    rl_valid = 1'b0;
    check(rl_done && rl_stat == exp_st, tag, {rl_done, rl_stat, 31'h0}, {1'b1, exp_st, 31'h0});
    model_rl(i, d, ds, er);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd('h200, "R1 word0 after reset");
    rd('h200 + 4 * 95, "R1 word95 after reset");
    for (int k = 0; k < 6; k++) rd(offs[k] + 8, "R1 bitmap row2 after reset");
    // R10 debug bit
    rd('h14, "R10 dbg low");
    dbg_en = 1'b1;
    rd('h14, "R10 dbg high");

    // R2 shadow write/read
    wr('h200 + 4 * 5, 32'hA5A5_0005);
    wr('h200 + 4 * 95, 32'h1234_005F);
    rd('h200 + 4 * 5, "R2 word5");
    rd('h200 + 4 * 95, "R2 word95");

    // R6/R7 lock rows, sticky
    wr('h7C, 32'h0000_0020);
    wr('h7C + 8, 32'h8000_0000);
    rd('h7C, "R6 swlock row0 bit5");
    rd('h7C + 8, "R6 swlock row2 bit31");
    wr('h7C, 32'h0);
    rd('h7C, "R7 zero write keeps lock");
    wr('h4C, 32'h0000_0001);
    wr('h64 + 4, 32'h0001_0000);
    rd('h4C, "R7 perm lock row0");
    rd('h64 + 4, "R6 prog lock row1");

    // R3 locked writes ignored
    wr('h200 + 4 * 5, 32'hDEAD_BEEF);
    wr('h200 + 4 * 95, 32'hDEAD_BEEF);
    wr('h200 + 4 * 6, 32'h0000_0666);
    rd('h200 + 4 * 5, "R3 word5 locked");
    rd('h200 + 4 * 95, "R3 word95 locked");
    rd('h200 + 4 * 6, "R3 word6 unlocked");

    // R4 reload
    rl(10, 32'h0000_1234, 1'b0, 1'b0, 2'b00, "R4 clean reload status");
    rd('h200 + 4 * 10, "R4 reload data");
    rl(5, 32'h5555_AAAA, 1'b0, 1'b0, 2'b00, "R4 reload into swlocked word");
    rd('h200 + 4 * 5, "R4 reload overrides swlock");

    // R5 read-locked reload
    wr('h94 + 4, 32'h0000_0100);
    wr('h200 + 4 * 40, 32'h0000_4040);
    rl(40, 32'hDEAD_0040, 1'b0, 1'b0, 2'b00, "R5 reload status");
    rd('h200 + 4 * 40, "R5 read-locked reload gives zero");

    // R8/R9 flags and status priority
    rl(33, 32'h3333_3333, 1'b1, 1'b1, 2'b01, "R9 disturbed priority on reload");
    rl(34, 32'h3434_3434, 1'b0, 1'b1, 2'b10, "R9 error-only on reload");
    rd('h1C + 4, "R8 disturbed row1");
    rd('h34 + 4, "R8 error row1");
    rd('h200 + 4 * 33, "R9 host status disturbed");
    rd('h200 + 4 * 34, "R9 host status error");
    rl(33, 32'h3300_0033, 1'b0, 1'b0, 2'b00, "R8 clean reload status");
    rd('h1C + 4, "R8 disturbed cleared");
    rd('h34 + 4, "R8 error kept for word34");
    wr('h1C + 4, 32'hFFFF_FFFF);
    wr('h34, 32'hFFFF_FFFF);
    rd('h1C + 4, "R8 host write to flags ignored");
    rd('h34, "R8 host write to error row ignored");

    // R11 unmapped / unaligned
    rd('h200 + 4 * 96, "R11 index96 reads zero");
    rd('h3FC, "R11 top address reads zero");
    wr('h200 + 4 * 96, 32'hFFFF_FFFF);
    wr('h201, 32'hFFFF_FFFF);
    rl(100, 32'hFFFF_FFFF, 1'b0, 1'b0, 2'b00, "R11 out-of-range reload done");
    rd('h200, "R11 word0 untouched");
    rd('h201, "R11 unaligned read zero");
    rd('h200 + 4 * 96, "R11 index96 still zero");

    // R12 same-cycle collision
    @(negedge clk);
    host_addr = 10'('h200 + 4 * 12);
    host_wdata = 32'h0000_0C0C;
    host_wr = 1'b1;
    rl_idx = 7'd12;
    rl_data = 32'hC0DE_000C;
    rl_disturbed = 1'b0;
    rl_error = 1'b0;
    rl_valid = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    rl_valid = 1'b0;
    model_wr('h200 + 4 * 12, 32'h0000_0C0C);
    model_rl(12, 32'hC0DE_000C, 1'b0, 1'b0);
    rd('h200 + 4 * 12, "R12 reload wins");

    // R7/R1 reset clears locks
    do_reset();
    rd('h7C, "R7 lock cleared by reset");
    rd('h94 + 4, "R7 read lock cleared by reset");
    rd('h200 + 4 * 5, "R1 word5 after second reset");
    wr('h200 + 4 * 5, 32'h0BAD_F00D);
    rd('h200 + 4 * 5, "R7 write allowed after reset");

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R2 all reads answered", 34'(sbq.size()), '0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule